// File: doc/BRIEF.md
# Control-Flow Signature Checker

This block watches a program's progress through its basic blocks and flags control flow that goes somewhere it should not. It keeps a runtime signature register. Each time a block is entered, the register is folded with that block's difference value. It is also folded with an adjusting value, which is only nonzero on the alternate arm of a merge point. The result is then compared with the signature the block was assigned. A legal transition always lands exactly on the destination's signature. A jump that skips or reorders blocks leaves a value that does not match.

The block does not hold the control-flow graph. Every block-entry event brings its own difference value, adjusting value and expected signature. The instrumented program or a front-end supplies these. A start pulse loads the entry block's signature and clears any earlier error. Once an error is seen, it stays raised, and the register stops changing, so the faulting state can be inspected.

Top module: `cfs_checker`

## Requirements
- R1: After reset, `sig_o` equals the parameter `ENTRY_SIG` and `err_o` is 0.
- R2: An event accepted while no error is held updates `sig_o` one cycle later to the previous `sig_o` XOR `evt_diff_i` XOR `evt_adj_i`.
- R3: If that updated value equals `evt_expect_i`, `err_o` stays 0.
- R4: If that updated value differs from `evt_expect_i`, `err_o` becomes 1 one cycle after the event.
- R5: While `err_o` is 1, events are ignored: `err_o` stays 1 and `sig_o` does not change until a start pulse.
- R6: A start pulse loads `start_sig_i` into `sig_o` and clears `err_o` one cycle later. It takes priority over an event in the same cycle.
- R7: In a cycle with neither start nor event, `sig_o` and `err_o` hold.
- R8: At a merge point, both predecessors land on the destination signature. One path uses adjust 0. The other path uses adjust equal to the XOR of the two predecessor signatures.
- R9: Entering a block with the difference value meant for a different predecessor (for example S1 followed directly by S3) raises `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load start signature and clear error |
| start_sig_i | input | SIG_W | Entry block signature for a start pulse |
| evt_valid_i | input | 1 | Block-entry event strobe, one cycle per event |
| evt_diff_i | input | SIG_W | Difference value of the entered block |
| evt_adj_i | input | SIG_W | Path-dependent adjusting value |
| evt_expect_i | input | SIG_W | Assigned signature of the entered block |
| sig_o | output | SIG_W | Current runtime signature |
| err_o | output | 1 | Sticky control-flow error |

## Verification
The hardest states to reach from the ports are the alternate arm of a merge point and the frozen state after an error, since a plain random walk almost never produces either one. The stimulus therefore keeps a random table of block signatures and walks it legally. It sometimes routes a step through a third block's difference value with the matching adjust term, and sometimes corrupts one bit of a difference value. After a corruption it keeps sending events into the frozen state before recovering with a start pulse. Directed sequences cover the exact merge and skipped-block cases, as well as a start pulse that collides with an event.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  parameter int CFS_SIG_W = 16;
  typedef logic [CFS_SIG_W-1:0] sig_t;

  // Fold a block-entry event into the running signature.
  function automatic sig_t cfs_advance(input sig_t g, input sig_t diff, input sig_t adj);
    return g ^ diff ^ adj;
  endfunction

  // True when the folded signature misses the assigned one.
  function automatic logic cfs_differs(input sig_t got, input sig_t want);
    return |(got ^ want);
  endfunction
endpackage

// File: rtl/cfs_sig_reg.sv
module cfs_sig_reg
  import cfs_pkg::*;
#(
  parameter sig_t RESET_SIG = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  sig_t load_val,
  input  logic adv,
  input  sig_t adv_val,
  output sig_t g
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    g <= RESET_SIG;
    else if (load) g <= load_val;
    else if (adv)  g <= adv_val;
  end
endmodule

// File: rtl/cfs_err_reg.sv
module cfs_err_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic check,
  input  logic miss,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              err <= 1'b0;
    else if (clear)          err <= 1'b0;
    else if (check && miss)  err <= 1'b1;
  end
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker
  import cfs_pkg::*;
#(
  parameter int   SIG_W     = CFS_SIG_W,
  parameter sig_t ENTRY_SIG = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SIG_W-1:0] start_sig_i,
  input  logic             evt_valid_i,
  input  logic [SIG_W-1:0] evt_diff_i,
  input  logic [SIG_W-1:0] evt_adj_i,
  input  logic [SIG_W-1:0] evt_expect_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             err_o
);
  sig_t g_q;
  sig_t g_next;
  logic err_q;
  logic upd_en;
  logic miss;

  // Named internal events, brought out for the checker.
  assign upd_en = evt_valid_i && !start_i && !err_q;
  assign g_next = cfs_advance(g_q, evt_diff_i, evt_adj_i);
  assign miss   = cfs_differs(g_next, evt_expect_i);

  cfs_sig_reg #(.RESET_SIG(ENTRY_SIG)) u_sig (
    .clk(clk), .rst_n(rst_n),
    .load(start_i), .load_val(start_sig_i),
    .adv(upd_en), .adv_val(g_next),
    .g(g_q)
  );

  cfs_err_reg u_err (
    .clk(clk), .rst_n(rst_n),
    .clear(start_i), .check(upd_en), .miss(miss),
    .err(err_q)
  );

  assign sig_o = g_q;
  assign err_o = err_q;
endmodule

// File: rtl/cfs_checker_sva.sv
module cfs_checker_sva #(
  parameter int SIG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [SIG_W-1:0] start_sig_i,
  input logic             evt_valid_i,
  input logic [SIG_W-1:0] evt_diff_i,
  input logic [SIG_W-1:0] evt_adj_i,
  input logic [SIG_W-1:0] evt_expect_i,
  input logic [SIG_W-1:0] sig_o,
  input logic             err_o,
  input logic             upd_en
);
  p_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_i && !start_i && !err_o |=> sig_o == ($past(sig_o) ^ $past(evt_diff_i) ^ $past(evt_adj_i)));

  p_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_i && !start_i && !err_o && ((sig_o ^ evt_diff_i ^ evt_adj_i) == evt_expect_i) |=> !err_o);

  p_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_i && !start_i && !err_o && ((sig_o ^ evt_diff_i ^ evt_adj_i) != evt_expect_i) |=> err_o);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start_i |=> err_o && $stable(sig_o));

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> !err_o && evt_valid_i && !start_i);

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !err_o && sig_o == $past(start_sig_i));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !evt_valid_i |=> $stable(sig_o) && $stable(err_o));
endmodule

bind cfs_checker cfs_checker_sva #(.SIG_W(SIG_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_sig_i(start_sig_i),
  .evt_valid_i(evt_valid_i), .evt_diff_i(evt_diff_i), .evt_adj_i(evt_adj_i),
  .evt_expect_i(evt_expect_i), .sig_o(sig_o), .err_o(err_o), .upd_en(upd_en)
);

// File: tb/tb_cfs_checker.sv
module tb_cfs_checker;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [W-1:0] ENTRY = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] start_sig_i = '0;
  logic evt_valid_i = 1'b0;
  logic [W-1:0] evt_diff_i = '0, evt_adj_i = '0, evt_expect_i = '0;
  logic [W-1:0] sig_o;
  logic err_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] m_sig;
  logic m_err;
  logic [W-1:0] blk [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfs_checker #(.SIG_W(W), .ENTRY_SIG(ENTRY)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_sig_i(start_sig_i),
    .evt_valid_i(evt_valid_i), .evt_diff_i(evt_diff_i), .evt_adj_i(evt_adj_i),
    .evt_expect_i(evt_expect_i), .sig_o(sig_o), .err_o(err_o)
  );

  function automatic logic [W-1:0] land(input logic [W-1:0] g, input logic [W-1:0] d,
                                        input logic [W-1:0] a);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (g[i] + d[i] + a[i]) % 2 == 1;
    return r;
  endfunction

  task automatic check_sig(input string tag, input logic [W-1:0] exp);
    n_checks++;
    if (sig_o !== exp) begin
      n_fail++;
      $display("FAIL %s sig_o actual=%h expected=%h", tag, sig_o, exp);
    end
  endtask

  task automatic check_err(input string tag, input logic exp);
    n_checks++;
    if (err_o !== exp) begin
      n_fail++;
      $display("FAIL %s err_o actual=%b expected=%b", tag, err_o, exp);
    end
  endtask

  // One cycle of stimulus; model updates and outputs are compared after the edge.
  task automatic step(input logic st, input logic [W-1:0] ss, input logic v,
                      input logic [W-1:0] d, input logic [W-1:0] a, input logic [W-1:0] e,
                      input string extra);
    string ts, te;
    logic [W-1:0] nx;
    @(negedge clk);
    start_i = st; start_sig_i = ss; evt_valid_i = v;
    evt_diff_i = d; evt_adj_i = a; evt_expect_i = e;
    if (st) begin
      m_sig = ss; m_err = 1'b0; ts = "R6"; te = "R6";
    end else if (!v) begin
      ts = "R7"; te = "R7";
    end else if (m_err) begin
      ts = "R5"; te = "R5";
    end else begin
      nx = land(m_sig, d, a);
      m_err = (nx != e);
      m_sig = nx;
      ts = "R2"; te = m_err ? "R4" : "R3";
    end
    if (extra != "") begin ts = extra; te = extra; end
    @(posedge clk);
    #1;
    check_sig(ts, m_sig);
    check_err(te, m_err);
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, '0, '0, "");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] s1, s2, s3, s5;
    int cur;
    void'($urandom(32'd1234));
    m_sig = ENTRY; m_err = 1'b0;
    #(CLK_PERIOD * 2 + 2);
    check_sig("R1", ENTRY);
    check_err("R1", 1'b0);
    rst_n = 1'b1;
    idle();

    // Directed: merge point reached from two predecessors (R8).
    s1 = 16'h1111; s2 = 16'h2D2D; s3 = 16'h3C0F; s5 = 16'h5A5A;
    step(1'b1, s1, 1'b0, '0, '0, '0, "R6");
    step(1'b0, '0, 1'b1, s1 ^ s5, '0, s5, "R8");
    step(1'b1, s3, 1'b0, '0, '0, '0, "R6");
    step(1'b0, '0, 1'b1, s1 ^ s5, s1 ^ s3, s5, "R8");

    // Directed: S1 followed directly by S3 (R9), then frozen (R5).
    step(1'b1, s1, 1'b0, '0, '0, '0, "R6");
    step(1'b0, '0, 1'b1, s2 ^ s3, '0, s3, "R9");
    step(1'b0, '0, 1'b1, s3 ^ s5, '0, s5, "R5");
    idle();
    // Start colliding with an event: start wins (R6).
    step(1'b1, s2, 1'b1, 16'hFFFF, 16'h0F0F, 16'h1234, "R6");
    step(1'b0, '0, 1'b1, s2 ^ s3, '0, s3, "R3");

    // Random walk over a block table with merges, corruptions and recovery.
    for (int i = 0; i < 8; i++) blk[i] = W'($urandom());
    cur = 0;
    step(1'b1, blk[0], 1'b0, '0, '0, '0, "");
    for (int n = 0; n < 3000; n++) begin
      int nxt, oth, r;
      logic [W-1:0] d, a;
      r = $urandom_range(0, 15);
      nxt = $urandom_range(0, 7);
      oth = $urandom_range(0, 7);
      d = blk[cur] ^ blk[nxt];
      a = '0;
      if (r < 4) begin
        d = blk[oth] ^ blk[nxt];
        a = blk[cur] ^ blk[oth];
      end
      if (r == 5) d[$urandom_range(0, W-1)] ^= 1'b1;
      if (r == 6) idle();
      else if (m_err && r > 12) begin
        step(1'b1, blk[nxt], 1'b0, '0, '0, '0, "");
        cur = nxt;
      end else begin
        step(1'b0, '0, 1'b1, d, a, blk[nxt], "");
        if (!m_err) cur = nxt;
      end
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule